// File: doc/BRIEF.md
# Word-to-Byte Host Bus Splitter

This block sits between a 16-bit host port that works in memory mode and an 8-bit local peripheral bus. When splitting is turned on, one 16-bit host read or write becomes two timed 8-bit strobes on the peripheral side. The low byte goes first, at local address bit 0 equal to 0. The high byte follows at local address bit 0 equal to 1. A wait output holds the host until both byte cycles have finished. When splitting is off, or the access does not qualify, the access goes through as a single 8-bit strobe.

A small bus-control register sets the timing and mapping:
- the strobe width;
- the setup delay before each strobe;
- the polarity of the byte-high-enable pin;
- whether host address bits A3..A1 or A2..A0 drive the three local address lines.

The peripheral can stretch any strobe by holding its ready input low. On a read, the two bytes are put back together into one word. On a write, the word is split into its two bytes.

Top module: `hostBusSplitter`

## Requirements
- R1: After reset, `hostWait`, `perRd` and `perWr` are low, and `perBhe` is low because the polarity field resets to active-high. All register fields reset to zero.
- R2: An access is split only when all four of these hold: `ctlSplitEn`=1, `memMode`=1, `hostCeHi`=1 and `hostAddr[0]`=0. Any other access produces exactly one strobe.
- R3: A split access produces two strobes. The first uses local address bit 0 = 0 and carries the low byte. The second uses local address bit 0 = 1 and carries the high byte. `perRd` is high on reads, `perWr` is high on writes, and the two are never high together.
- R4: `hostWait` rises in the cycle after a request is accepted. It stays high through every delay and strobe cycle and falls one clock after the last strobe ends. With no stretching it is high for (D+1)+(W+1) cycles per byte cycle.
- R5: Each strobe lasts W+1 cycles, where W is the width field, when ready is held high.
- R6: Each strobe is preceded by D+1 cycles with no strobe and `hostWait` high, where D is the delay field.
- R7: A strobe ends only in a cycle where `perReady` is high and the strobe has lasted at least W+1 cycles. If ready is low for the first N cycles of the strobe, the strobe lasts max(W,N)+1 cycles.
- R8: Let B be the local base address. With the shift field set, B = `hostAddr[3:1]`. With it clear, B = `hostAddr[2:0]`. A single-strobe access uses B. A split access uses {B[2:1], byte index}.
- R9: While a strobe is running, the byte-high-enable level is active during the high-byte strobe of a split access. In a single-strobe access it is active when `hostCeHi` is high. The pin shows the active level XOR the polarity field. While `hostWait` is low, the pin sits at the polarity field value.
- R10: On a split read, `hostRdata` = {high byte, low byte} when `hostWait` falls. On a single-strobe read it is {8'h00, byte}.
- R11: Write data is captured when the request is accepted. Changing `hostWdata` afterwards has no effect on what is written. `perWdata` and `perAddr` hold steady for the whole length of a write strobe.
- R12: A request raised while an access is in progress, including the cycle after the last strobe, is ignored. It produces no extra strobes, and `hostWait` stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWe | input | 1 | Load the bus-control register fields |
| ctlSplitEn | input | 1 | Splitting enable field |
| ctlAddrShift | input | 1 | Address shift field |
| ctlBhePol | input | 1 | Byte-high-enable polarity field (1 = active low) |
| ctlWidth | input | WIDTH_W | Strobe width field W |
| ctlDelay | input | DELAY_W | Setup delay field D |
| memMode | input | 1 | Interface is in memory mode |
| hostReq | input | 1 | One-cycle host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostCeHi | input | 1 | Odd-byte card enable, active high |
| hostAddr | input | LOC_AW+1 | Host address A3..A0 |
| hostWdata | input | 16 | Host write word |
| hostWait | output | 1 | Host wait, high while busy |
| hostRdata | output | 16 | Assembled read word |
| perAddr | output | LOC_AW | Local peripheral address |
| perWdata | output | 8 | Byte to the peripheral |
| perRdata | input | 8 | Byte from the peripheral |
| perRd | output | 1 | Peripheral read strobe |
| perWr | output | 1 | Peripheral write strobe |
| perBhe | output | 1 | Byte-high-enable pin |
| perReady | input | 1 | Peripheral ready, low to stretch |

## Verification
Some properties are checked by assertions on every cycle:
- a strobe appears only while `hostWait` is high;
- the read and write strobes are never high together;
- `hostWait` falls only in the cycle right after a strobe;
- the idle byte-high-enable level matches the polarity field;
- write address and data stay stable during a strobe;
- no strobe ends before W+1 cycles.

Other properties only the bench scenarios can show:
- the exact counts of delay and strobe cycles;
- the byte ordering and local addresses;
- the assembled read word;
- the four conditions that decide whether an access is split;
- that requests arriving while busy are ignored.

The bench shows these by sweeping width, delay, ready stretch, shift, polarity and direction.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } stateT;

  typedef struct packed {
    logic load;     // capture host address and write data
    logic split;    // current access is split into two bytes
    logic byteSel;  // 0 = low byte cycle, 1 = high byte cycle
    logic capLo;    // latch low read byte
    logic capWord;  // latch final read word
  } ctlT;
endpackage

// File: rtl/splitCtrl.sv
module splitCtrl
  import splitPkg::*;
#(
  parameter int WIDTH_W = 3,
  parameter int DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic               hostCeHi,
  input  logic               hostAddrLsb,
  input  logic               memMode,
  input  logic               cfgSplitEn,
  input  logic               cfgBhePol,
  input  logic [WIDTH_W-1:0] cfgWidth,
  input  logic [DELAY_W-1:0] cfgDelay,
  input  logic               perReady,
  output ctlT                ctl,
  output logic               hostWait,
  output logic               perRd,
  output logic               perWr,
  output logic               perBhe
);
  localparam int CNT_W = (WIDTH_W > DELAY_W) ? WIDTH_W : DELAY_W;

  stateT             state;
  logic [CNT_W-1:0]  cnt;
  logic              byteIdx;
  logic              splitQ;
  logic              weQ;
  logic              ceHiQ;
  logic              splitNow;
  logic              delayDone;
  logic              strobeEnd;
  logic              lastByte;

  assign splitNow  = cfgSplitEn && memMode && hostCeHi && !hostAddrLsb;
  assign delayDone = (state == ST_DELAY) && (cnt >= CNT_W'(cfgDelay));
  assign strobeEnd = (state == ST_STROBE) && (cnt >= CNT_W'(cfgWidth)) && perReady;
  assign lastByte  = !splitQ || byteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      byteIdx <= 1'b0;
      splitQ  <= 1'b0;
      weQ     <= 1'b0;
      ceHiQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (hostReq) begin
            state   <= ST_DELAY;
            cnt     <= '0;
            byteIdx <= 1'b0;
            splitQ  <= splitNow;
            weQ     <= hostWe;
            ceHiQ   <= hostCeHi;
          end
        end
        ST_DELAY: begin
          if (delayDone) begin
            state <= ST_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (strobeEnd) begin
            cnt <= '0;
            if (lastByte) begin
              state <= ST_DONE;
            end else begin
              state   <= ST_DELAY;
              byteIdx <= 1'b1;
            end
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && hostReq;
    ctl.split   = splitQ;
    ctl.byteSel = byteIdx;
    ctl.capLo   = strobeEnd && !weQ && !lastByte;
    ctl.capWord = strobeEnd && !weQ && lastByte;
  end

  assign hostWait = (state == ST_DELAY) || (state == ST_STROBE);
  assign perRd    = (state == ST_STROBE) && !weQ;
  assign perWr    = (state == ST_STROBE) && weQ;
  assign perBhe   = (hostWait && (splitQ ? byteIdx : ceHiQ)) ^ cfgBhePol;
endmodule

// File: rtl/splitData.sv
module splitData
  import splitPkg::*;
#(
  parameter int LOC_AW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlT                 ctl,
  input  logic                cfgAddrShift,
  input  logic [LOC_AW:0]     hostAddr,
  input  logic [WORD_W-1:0]   hostWdata,
  input  logic [BYTE_W-1:0]   perRdata,
  output logic [LOC_AW-1:0]   perAddr,
  output logic [BYTE_W-1:0]   perWdata,
  output logic [WORD_W-1:0]   hostRdata
);
  logic [LOC_AW:0]     addrQ;
  logic [WORD_W-1:0]   wdataQ;
  logic [BYTE_W-1:0]   loByte;
  logic [LOC_AW-1:0]   baseAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      loByte    <= '0;
      hostRdata <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
      end
      if (ctl.capLo) loByte <= perRdata;
      if (ctl.capWord) begin
        hostRdata <= ctl.split ? {perRdata, loByte} : {{BYTE_W{1'b0}}, perRdata};
      end
    end
  end

  assign baseAddr = cfgAddrShift ? addrQ[LOC_AW:1] : addrQ[LOC_AW-1:0];
  assign perAddr  = ctl.split ? {baseAddr[LOC_AW-1:1], ctl.byteSel} : baseAddr;
  assign perWdata = (ctl.split && ctl.byteSel) ? wdataQ[WORD_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];
endmodule

// File: rtl/hostBusSplitter.sv
module hostBusSplitter
  import splitPkg::*;
#(
  parameter int LOC_AW  = 3,
  parameter int WIDTH_W = 3,
  parameter int DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWe,
  input  logic               ctlSplitEn,
  input  logic               ctlAddrShift,
  input  logic               ctlBhePol,
  input  logic [WIDTH_W-1:0] ctlWidth,
  input  logic [DELAY_W-1:0] ctlDelay,
  input  logic               memMode,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic               hostCeHi,
  input  logic [LOC_AW:0]    hostAddr,
  input  logic [15:0]        hostWdata,
  output logic               hostWait,
  output logic [15:0]        hostRdata,
  output logic [LOC_AW-1:0]  perAddr,
  output logic [7:0]         perWdata,
  input  logic [7:0]         perRdata,
  output logic               perRd,
  output logic               perWr,
  output logic               perBhe,
  input  logic               perReady
);
  logic               cfgSplitEn;
  logic               cfgAddrShift;
  logic               cfgBhePol;
  logic [WIDTH_W-1:0] cfgWidth;
  logic [DELAY_W-1:0] cfgDelay;
  ctlT                ctl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSplitEn   <= 1'b0;
      cfgAddrShift <= 1'b0;
      cfgBhePol    <= 1'b0;
      cfgWidth     <= '0;
      cfgDelay     <= '0;
    end else if (ctlWe) begin
      cfgSplitEn   <= ctlSplitEn;
      cfgAddrShift <= ctlAddrShift;
      cfgBhePol    <= ctlBhePol;
      cfgWidth     <= ctlWidth;
      cfgDelay     <= ctlDelay;
    end
  end

  splitCtrl #(.WIDTH_W(WIDTH_W), .DELAY_W(DELAY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWe(hostWe), .hostCeHi(hostCeHi),
    .hostAddrLsb(hostAddr[0]), .memMode(memMode),
    .cfgSplitEn(cfgSplitEn), .cfgBhePol(cfgBhePol),
    .cfgWidth(cfgWidth), .cfgDelay(cfgDelay),
    .perReady(perReady), .ctl(ctl),
    .hostWait(hostWait), .perRd(perRd), .perWr(perWr), .perBhe(perBhe)
  );

  splitData #(.LOC_AW(LOC_AW)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgAddrShift(cfgAddrShift), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .perRdata(perRdata), .perAddr(perAddr), .perWdata(perWdata),
    .hostRdata(hostRdata)
  );
endmodule

// File: rtl/splitChk.sv
module splitChk #(
  parameter int LOC_AW  = 3,
  parameter int WIDTH_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWait,
  input logic               perRd,
  input logic               perWr,
  input logic               perBhe,
  input logic               cfgBhePol,
  input logic [WIDTH_W-1:0] cfgWidth,
  input logic [LOC_AW-1:0]  perAddr,
  input logic [7:0]         perWdata
);
  logic       stb;
  logic [7:0] stbLen;

  assign stb = perRd || perWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbLen <= '0;
    else if (stb) stbLen <= (stbLen != 8'hFF) ? stbLen + 8'd1 : stbLen;
    else stbLen <= '0;
  end

  // R4
  strobe_in_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb |-> hostWait);

  // R3
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(perRd && perWr));

  // R4
  wait_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostWait) |-> $past(stb));

  // R9
  bhe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostWait |-> (perBhe == cfgBhePol));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perWr && $past(perWr)) |-> ($stable(perWdata) && $stable(perAddr)));

  // R5
  min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb) |-> (stbLen > 8'(cfgWidth)));
endmodule

bind hostBusSplitter splitChk #(.LOC_AW(LOC_AW), .WIDTH_W(WIDTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWait(hostWait), .perRd(perRd), .perWr(perWr),
  .perBhe(perBhe), .cfgBhePol(cfgBhePol), .cfgWidth(cfgWidth),
  .perAddr(perAddr), .perWdata(perWdata)
);

// File: tb/hostBusSplitter_bench.sv
`timescale 1ns/1ps
module hostBusSplitter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWe = 0, ctlSplitEn = 0, ctlAddrShift = 0, ctlBhePol = 0;
  logic [2:0] ctlWidth = 0, ctlDelay = 0;
  logic memMode = 1, hostReq = 0, hostWe = 0, hostCeHi = 0;
  logic [3:0] hostAddr = 0;
  logic [15:0] hostWdata = 0;
  logic hostWait;
  logic [15:0] hostRdata;
  logic [2:0] perAddr;
  logic [7:0] perWdata, perRdata;
  logic perRd, perWr, perBhe;
  logic perReady = 1;
  logic [7:0] mem [8];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign perRdata = mem[perAddr];

  hostBusSplitter u_hostBusSplitter (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic en, input logic sh, input logic pol, input int w, input int d);
    ctlWe = 1; ctlSplitEn = en; ctlAddrShift = sh; ctlBhePol = pol;
    ctlWidth = 3'(w); ctlDelay = 3'(d);
    @(negedge clk);
    ctlWe = 0;
    @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [3:0] addr, input logic [15:0] wd,
                        input logic ce, input logic expSplit, input int w, input int d,
                        input int n, input logic sh, input logic pol);
    int waitCnt = 0, nStb = 0, cyc = 0, gap = 0, maxWn, expStb, expWait;
    logic prev = 0, stb;
    int lens[2], gaps[2];
    logic [2:0] addrs[2];
    logic bhes[2];
    logic [7:0] wds[2];
    logic dirOk[2];
    logic [2:0] base, expA;
    logic [15:0] expR;
    base = sh ? addr[3:1] : addr[2:0];
    expStb = expSplit ? 2 : 1;
    maxWn = (w > n) ? w : n;
    expWait = expStb * ((d + 1) + (maxWn + 1));
    expR = expSplit ? {mem[{base[2:1], 1'b1}], mem[{base[2:1], 1'b0}]} : {8'h00, mem[base]};
    for (int i = 0; i < 2; i++) begin lens[i] = 0; gaps[i] = 0; addrs[i] = 0; bhes[i] = 0; wds[i] = 0; dirOk[i] = 0; end
    hostReq = 1; hostWe = we; hostAddr = addr; hostWdata = wd; hostCeHi = ce;
    @(negedge clk);
    hostReq = 0; hostWdata = ~wd;  // R11: late change must not matter
    chk(hostWait == 1'b1, "R4 wait rises after accept", hostWait, 1);
    for (int guard = 0; guard < 200; guard++) begin
      stb = perRd | perWr;
      if (!hostWait) break;
      waitCnt++;
      if (stb) begin
        if (!prev) begin
          if (nStb < 2) begin
            addrs[nStb] = perAddr; bhes[nStb] = perBhe; wds[nStb] = perWdata;
            gaps[nStb] = gap; dirOk[nStb] = (perRd == !we) && (perWr == we);
          end
          nStb++;
          gap = 0;
        end
        cyc++;
        if (nStb <= 2) lens[nStb-1] = cyc;
        if (perWr) mem[perAddr] = perWdata;
      end else begin
        cyc = 0;
        gap++;
      end
      perReady = stb ? (cyc > n) : 1'b1;  // R7 stretch
      prev = stb;
      if (waitCnt == 2) begin
        hostReq = 1; hostAddr = addr ^ 4'h2; hostWe = !we;  // R12 busy request
      end else begin
        hostReq = 0;
      end
      @(negedge clk);
    end
    hostReq = 0; perReady = 1;
    chk(nStb == expStb, "R2 strobe count", nStb, expStb);
    chk(waitCnt == expWait, "R4 wait cycles", waitCnt, expWait);
    chk((perRd | perWr) == 1'b0, "R4 no strobe after wait falls", perRd | perWr, 0);
    for (int k = 0; k < expStb && k < nStb; k++) begin
      expA = expSplit ? {base[2:1], 1'(k)} : base;
      chk(addrs[k] == expA, sh ? "R8 shifted address" : "R3 byte address", addrs[k], expA);
      chk(lens[k] == maxWn + 1, (n > 0) ? "R7 stretched strobe" : "R5 strobe width", lens[k], maxWn + 1);
      chk(gaps[k] == d + 1, "R6 setup delay", gaps[k], d + 1);
      chk(bhes[k] == ((expSplit ? 1'(k) : ce) ^ pol), "R9 bhe level", bhes[k], (expSplit ? 1'(k) : ce) ^ pol);
      chk(dirOk[k], "R3 strobe direction", dirOk[k], 1);
      if (we) chk(wds[k] == ((k == 1) ? wd[15:8] : wd[7:0]), "R11 write byte", wds[k],
                  (k == 1) ? wd[15:8] : wd[7:0]);
    end
    if (!we) chk(hostRdata == expR, "R10 read word", hostRdata, expR);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(hostWait == 1'b0 && !(perRd | perWr), "R12 busy request ignored", hostWait, 0);
    end
    chk(perBhe == pol, "R9 idle bhe level", perBhe, pol);
  endtask

  initial begin
    int it = 0;
    for (int a = 0; a < 8; a++) mem[a] = 8'h30 + 8'(a * 17);
    #1;
    chk(hostWait == 0 && perRd == 0 && perWr == 0, "R1 reset strobes", {hostWait, perRd, perWr}, 0);
    chk(perBhe == 0, "R1 reset bhe", perBhe, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(hostWait == 0 && perBhe == 0, "R1 after reset", {hostWait, perBhe}, 0);
    // R2 default register: splitting off, single strobe even with qualifying access
    access(1'b0, 4'h4, 16'h0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 1'b0);
    for (int w = 0; w < 3; w++)
      for (int d = 0; d < 3; d++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            for (int n = 0; n < 4; n += 3)
              for (int we = 0; we < 2; we++) begin
                logic [3:0] addr;
                addr = 4'((it * 6) & 14);
                setCfg(1'b1, 1'(s), 1'(p), w, d);
                access(1'(we), addr, 16'hA50F ^ 16'(it * 257), 1'b1, 1'b1, w, d, n, 1'(s), 1'(p));
                it++;
              end
    // R2 non-qualifying accesses fall back to one strobe
    for (int we = 0; we < 2; we++) begin
      setCfg(1'b0, 1'b0, 1'b0, 1, 1);
      access(1'(we), 4'h6, 16'h1234, 1'b1, 1'b0, 1, 1, 0, 1'b0, 1'b0);
      setCfg(1'b1, 1'b0, 1'b1, 1, 0);
      memMode = 0;
      access(1'(we), 4'h2, 16'h5678, 1'b1, 1'b0, 1, 0, 0, 1'b0, 1'b1);
      memMode = 1;
      access(1'(we), 4'h2, 16'h9ABC, 1'b0, 1'b0, 1, 0, 0, 1'b0, 1'b1);
      access(1'(we), 4'h5, 16'hDEF0, 1'b1, 1'b0, 1, 0, 2, 1'b0, 1'b1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule